// File: doc/BRIEF.md
# Key-Sequence Register Write Lock

This block is a small bank of memory-mapped configuration registers with a write guard in front of it. A simple single-cycle register bus reaches it with an address, a write strobe, write data, a read strobe and read data. After reset the guard is closed. In that state the configuration registers can be read, but writes to them are dropped and a one-cycle error pulse marks each dropped write.

To open the guard, software writes two magic words to two key registers in order. Software closes it again by writing any other word to either key register. A group of message registers sits outside the guard and takes writes at all times. One identification register returns a fixed word and never changes. Key registers read as zero. Unmapped addresses read as zero and drop their writes.

The address map, the counts of configuration and message registers, the key words, the identification word and the reset value of the configuration registers are all parameters.

Top module: `cfg_guard_bank`

## Requirements
- R1: After reset, `unlocked_o` is 0, `wr_blocked_o` is 0 and every configuration register reads back `CFG_RST` (default 0x000000F0).
- R2: The identification register (default address 0) always reads `ID_VALUE` (default 0x3C5900A7). Writes to it are ignored whether the guard is open or closed.
- R3: Writing `KEY0` (0x83E70B13) to key register A (default address 1) and then `KEY1` (0x95A4F1E0) to key register B (default address 2) opens the guard. `unlocked_o` reads 1 in the cycle after the second write's clock edge.
- R4: Writing `KEY1` to key register B while fully closed leaves the guard closed. Only the intermediate state reached by a correct first key lets `KEY1` open it.
- R5: Any write to key register A that is not `KEY0`, or to key register B that is not `KEY1`, closes the guard completely from any state.
- R6: Writing `KEY0` to key register A while the guard is open returns it to the intermediate state. `unlocked_o` drops, and `KEY1` must be written again to reopen.
- R7: While `unlocked_o` is 0, writes to configuration registers (default addresses 4..7) leave their contents unchanged, and the registers stay readable.
- R8: While `unlocked_o` is 1, a write to a configuration register is visible on a read in the next cycle.
- R9: Message registers (default addresses 8..9) accept every write, open or closed.
- R10: Reads of key registers and of unmapped addresses return 0. Writes to unmapped addresses change no register.
- R11: `wr_blocked_o` is 1 for exactly the cycle after a configuration write that the closed guard dropped, and 0 after every other access.
- R12: `bus_rdata` is 0 whenever `bus_re` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Word address of the access |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | DW | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DW | Read data, combinational from address |
| unlocked_o | output | 1 | Guard open |
| wr_blocked_o | output | 1 | One-cycle pulse after a dropped configuration write |

## Verification
A lock state machine in the wrong state shows up at the ports one cycle after the key write that caused it. It appears on `unlocked_o` and, on the next configuration write, on `wr_blocked_o` and in the read-back value. A misdecoded address or a misrouted write enable shows up on the first read that follows, because a full-address sweep reads every location after each write sweep. That sweep includes the identification, key and unmapped locations. The bench replays every key ordering from each of the three lock states, so a wrong transition cannot stay hidden for more than one access.

// File: rtl/cfg_guard_pkg.sv
`timescale 1ns/1ps
package cfg_guard_pkg;
   typedef enum logic [1:0] {
      LK_LOCKED  = 2'd0,
      LK_KEY0_OK = 2'd1,
      LK_OPEN    = 2'd2
   } lock_state_e;

   typedef enum logic [2:0] {
      RG_NONE = 3'd0,
      RG_ID   = 3'd1,
      RG_KEYA = 3'd2,
      RG_KEYB = 3'd3,
      RG_CFG  = 3'd4,
      RG_MSG  = 3'd5
   } region_e;
endpackage

// File: rtl/cgb_addr_decode.sv
`timescale 1ns/1ps
module cgb_addr_decode
   import cfg_guard_pkg::*;
#(
   parameter int AW        = 4,
   parameter int IDX_W     = 2,
   parameter int ID_ADDR   = 0,
   parameter int KEYA_ADDR = 1,
   parameter int KEYB_ADDR = 2,
   parameter int CFG_BASE  = 4,
   parameter int N_CFG     = 4,
   parameter int MSG_BASE  = 8,
   parameter int N_MSG     = 2
) (
   input  logic [AW-1:0]    addr_i,
   output region_e          region_o,
   output logic [IDX_W-1:0] idx_o
);
   int a;
   assign a = int'(addr_i);

   always_comb begin
      region_o = RG_NONE;
      idx_o    = '0;
      if (a == ID_ADDR) begin
         region_o = RG_ID;
      end else if (a == KEYA_ADDR) begin
         region_o = RG_KEYA;
      end else if (a == KEYB_ADDR) begin
         region_o = RG_KEYB;
      end else if (a >= CFG_BASE && a < CFG_BASE + N_CFG) begin
         region_o = RG_CFG;
         idx_o    = IDX_W'(a - CFG_BASE);
      end else if (a >= MSG_BASE && a < MSG_BASE + N_MSG) begin
         region_o = RG_MSG;
         idx_o    = IDX_W'(a - MSG_BASE);
      end
   end
endmodule

// File: rtl/cgb_key_fsm.sv
`timescale 1ns/1ps
module cgb_key_fsm
   import cfg_guard_pkg::*;
#(
   parameter int            DW   = 32,
   parameter logic [DW-1:0] KEY0 = 32'h83E7_0B13,
   parameter logic [DW-1:0] KEY1 = 32'h95A4_F1E0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_keya_i,
   input  logic          wr_keyb_i,
   input  logic [DW-1:0] wdata_i,
   output logic          unlocked_o
);
   lock_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (wr_keya_i) begin
         state_d = (wdata_i == KEY0) ? LK_KEY0_OK : LK_LOCKED;
      end else if (wr_keyb_i) begin
         if (wdata_i != KEY1)           state_d = LK_LOCKED;
         else if (state_q == LK_KEY0_OK) state_d = LK_OPEN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= LK_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked_o = (state_q == LK_OPEN);

   a_r3_open_after_key1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked_o) |-> $past(wr_keyb_i && wdata_i == KEY1));
   a_r4_no_skip_first_key: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LK_LOCKED && wr_keyb_i) |=> !unlocked_o);
   a_r5_bad_key_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_keya_i && wdata_i != KEY0) || (wr_keyb_i && wdata_i != KEY1)) |=> state_q == LK_LOCKED);
   a_r6_rekey_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_keya_i && wdata_i == KEY0) |=> !unlocked_o);
endmodule

// File: rtl/cgb_reg_file.sv
`timescale 1ns/1ps
module cgb_reg_file #(
   parameter int            N     = 4,
   parameter int            DW    = 32,
   parameter int            IDX_W = 2,
   parameter logic [DW-1:0] RST   = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [DW-1:0]         wdata_i,
   output logic [N-1:0][DW-1:0]  q_o
);
   for (genvar i = 0; i < N; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                             q_o[i] <= RST;
         else if (we_i && idx_i == IDX_W'(i))    q_o[i] <= wdata_i;
      end
   end

   a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));
endmodule

// File: rtl/cfg_guard_bank.sv
`timescale 1ns/1ps
module cfg_guard_bank
   import cfg_guard_pkg::*;
#(
   parameter int            AW        = 4,
   parameter int            DW        = 32,
   parameter int            ID_ADDR   = 0,
   parameter int            KEYA_ADDR = 1,
   parameter int            KEYB_ADDR = 2,
   parameter int            CFG_BASE  = 4,
   parameter int            N_CFG     = 4,
   parameter int            MSG_BASE  = 8,
   parameter int            N_MSG     = 2,
   parameter logic [DW-1:0] KEY0      = 32'h83E7_0B13,
   parameter logic [DW-1:0] KEY1      = 32'h95A4_F1E0,
   parameter logic [DW-1:0] ID_VALUE  = 32'h3C59_00A7,
   parameter logic [DW-1:0] CFG_RST   = 32'h0000_00F0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_we,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_re,
   output logic [DW-1:0] bus_rdata,
   output logic          unlocked_o,
   output logic          wr_blocked_o
);
   localparam int MAXN  = (N_CFG > N_MSG) ? N_CFG : N_MSG;
   localparam int IDX_W = ($clog2(MAXN) < 1) ? 1 : $clog2(MAXN);
   localparam int SPAN  = 1 << AW;

   // elaboration-time parameter checks
   if (N_CFG < 1 || N_MSG < 1) begin : g_bad_count
      $error("register counts must be at least one");
   end
   if (CFG_BASE + N_CFG > SPAN || MSG_BASE + N_MSG > SPAN) begin : g_bad_span
      $error("register ranges exceed the address space");
   end
   if (!(CFG_BASE + N_CFG <= MSG_BASE || MSG_BASE + N_MSG <= CFG_BASE)) begin : g_bad_overlap
      $error("configuration and message ranges overlap");
   end
   if (ID_ADDR == KEYA_ADDR || ID_ADDR == KEYB_ADDR || KEYA_ADDR == KEYB_ADDR) begin : g_bad_single
      $error("identification and key addresses must differ");
   end
   if (KEY0 == KEY1) begin : g_bad_keys
      $error("the two key words must differ");
   end

   region_e          region;
   logic [IDX_W-1:0] idx;
   logic             unlocked;
   logic             cfg_we, msg_we;
   logic [N_CFG-1:0][DW-1:0] cfg_q;
   logic [N_MSG-1:0][DW-1:0] msg_q;

   cgb_addr_decode #(
      .AW(AW), .IDX_W(IDX_W), .ID_ADDR(ID_ADDR), .KEYA_ADDR(KEYA_ADDR),
      .KEYB_ADDR(KEYB_ADDR), .CFG_BASE(CFG_BASE), .N_CFG(N_CFG),
      .MSG_BASE(MSG_BASE), .N_MSG(N_MSG)
   ) u_dec (
      .addr_i(bus_addr), .region_o(region), .idx_o(idx)
   );

   cgb_key_fsm #(.DW(DW), .KEY0(KEY0), .KEY1(KEY1)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .wr_keya_i(bus_we && region == RG_KEYA),
      .wr_keyb_i(bus_we && region == RG_KEYB),
      .wdata_i(bus_wdata), .unlocked_o(unlocked)
   );

   assign cfg_we = bus_we && region == RG_CFG && unlocked;
   assign msg_we = bus_we && region == RG_MSG;

   cgb_reg_file #(.N(N_CFG), .DW(DW), .IDX_W(IDX_W), .RST(CFG_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .idx_i(idx),
      .wdata_i(bus_wdata), .q_o(cfg_q)
   );

   cgb_reg_file #(.N(N_MSG), .DW(DW), .IDX_W(IDX_W), .RST('0)) u_msg (
      .clk(clk), .rst_n(rst_n), .we_i(msg_we), .idx_i(idx),
      .wdata_i(bus_wdata), .q_o(msg_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) wr_blocked_o <= 1'b0;
      else        wr_blocked_o <= bus_we && region == RG_CFG && !unlocked;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         case (region)
            RG_ID:   bus_rdata = ID_VALUE;
            RG_CFG:  bus_rdata = cfg_q[idx];
            RG_MSG:  bus_rdata = msg_q[idx];
            default: bus_rdata = '0;
         endcase
      end
   end

   assign unlocked_o = unlocked;

   a_r7_closed_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(cfg_q));
   a_r11_blocked_cause: assert property (@(posedge clk) disable iff (!rst_n)
      wr_blocked_o |-> $past(bus_we && !unlocked));
   a_r9_msg_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      msg_we |=> msg_q[$past(idx)] == $past(bus_wdata));
   a_r2_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && region == RG_ID) |-> bus_rdata == ID_VALUE);
   a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |-> bus_rdata == '0);
endmodule

// File: tb/sim_cfg_guard_bank.sv
`timescale 1ns/1ps
module sim_cfg_guard_bank;
   localparam logic [31:0] K0  = 32'h83E7_0B13;
   localparam logic [31:0] K1  = 32'h95A4_F1E0;
   localparam logic [31:0] IDV = 32'h3C59_00A7;
   localparam logic [31:0] CRST = 32'h0000_00F0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        we = 1'b0, re = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        unlocked, blk;

   int checks = 0, errors = 0;
   int st = 0;                 // 0 closed, 1 first key seen, 2 open
   logic [31:0] cfg_m [4];
   logic [31:0] msg_m [2];

   always #2.5 clk = ~clk;

   cfg_guard_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata),
      .unlocked_o(unlocked), .wr_blocked_o(blk)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input int a);
      if (a == 0) return IDV;
      if (a >= 4 && a <= 7) return cfg_m[a-4];
      if (a == 8 || a == 9) return msg_m[a-8];
      return 32'h0;            // keys and unmapped
   endfunction

   task automatic do_wr(input int a, input logic [31:0] d, input string req);
      logic eb;
      eb = (a >= 4 && a <= 7 && st != 2);
      @(negedge clk);
      addr = 4'(a); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      if (a == 1) st = (d == K0) ? 1 : 0;
      else if (a == 2) begin
         if (d != K1) st = 0;
         else if (st == 1) st = 2;
      end
      if (a >= 4 && a <= 7 && st == 2) cfg_m[a-4] = d;
      if (a == 8 || a == 9) msg_m[a-8] = d;
      chk({"R11 ", req}, {31'b0, blk}, {31'b0, eb});
      chk({"R3/R5 ", req}, {31'b0, unlocked}, {31'b0, st == 2});
   endtask

   task automatic read_all(input string req);
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         addr = 4'(a); re = 1'b1;
         #1;
         chk(req, rdata, exp_read(a));
         re = 1'b0;
      end
   endtask

   initial begin
      #1_000_000;
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) cfg_m[i] = CRST;
      for (int i = 0; i < 2; i++) msg_m[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R2 id, R10 zero reads
      chk("R1 unlocked after reset", {31'b0, unlocked}, 32'h0);
      chk("R1 blocked after reset", {31'b0, blk}, 32'h0);
      read_all("R1/R2/R10 reset sweep");

      // R7 R9 R10 R11 closed: write every address
      for (int a = 0; a < 16; a++) do_wr(a, 32'h1000_0000 + a * 32'h0101_0101, "closed sweep");
      read_all("R7/R9/R2/R10 closed readback");

      // R4 second key while closed has no effect
      do_wr(2, K1, "R4 key1 while closed");
      chk("R4 still closed", {31'b0, unlocked}, 32'h0);
      do_wr(1, K0, "R3 first key");
      do_wr(5, 32'hDEAD_0005, "R7 write in intermediate state");
      do_wr(2, K1, "R3 second key");
      chk("R3 open", {31'b0, unlocked}, 32'h1);

      // R8 open sweep (keys skipped to stay open)
      for (int a = 0; a < 16; a++)
         if (a != 1 && a != 2) do_wr(a, 32'h2000_0000 + a * 32'h0011_0011, "open sweep");
      read_all("R8/R9/R2/R10 open readback");

      // R6 first key again while open
      do_wr(1, K0, "R6 rekey");
      chk("R6 closed after rekey", {31'b0, unlocked}, 32'h0);
      do_wr(6, 32'h3333_0006, "R6 write after rekey");
      do_wr(2, K1, "R6 reopen");
      do_wr(6, 32'h4444_0006, "R8 write after reopen");
      read_all("R6/R8 readback");

      // R5 wrong keys from each state
      do_wr(2, 32'h0000_0001, "R5 bad key B while open");
      do_wr(1, K0, "R5 key A");
      do_wr(1, K1, "R5 key1 into A");
      do_wr(2, K1, "R5 key1 after bad A");
      chk("R5 stays closed", {31'b0, unlocked}, 32'h0);
      do_wr(1, K0, "R5 key A again");
      do_wr(2, K0, "R5 key0 into B");
      do_wr(2, K1, "R5 key1 after bad B");
      chk("R5 closed after bad B", {31'b0, unlocked}, 32'h0);
      do_wr(1, K0, "R3 open again");
      do_wr(2, K1, "R3 open again B");
      do_wr(1, 32'h8000_0000, "R5 bad key A while open");
      do_wr(7, 32'h5555_0007, "R7 closed after bad A");
      read_all("R5/R7 readback");

      // R12 no read strobe
      @(negedge clk);
      addr = 4'd0; re = 1'b0;
      #1;
      chk("R12 idle read id", rdata, 32'h0);
      addr = 4'd8;
      #1;
      chk("R12 idle read msg", rdata, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule